// File: doc/BRIEF.md
# Gated Prescaled Period Timer

This block is a 16-bit up-counter that counts toward a programmable period value. It reloads to zero on the increment after it reaches that value. The counter can be driven by one of two sources. The first is a free-running internal enable tick passed through a selectable prescaler. The second is rising edges on an external pin, optionally passed through a two-stage synchronizer. In the gated accumulation mode the same pin acts as a gate instead: internal ticks count only while it is high, and its falling edge raises the event flag.

Software reaches the block through a small word-addressed register bus. The bus holds control, count, period and a write-one-to-clear event flag, all readable at any time. Two status inputs decide whether counting continues while the core idles or sleeps. The interrupt request is the event flag qualified by an enable bit.

Top module: `gated_period_timer`

## Requirements
- R1: After reset the count reads 0x0000, the period reads 0xFFFF, control reads 0, the flag reads 0 and irqOut is low.
- R2: Bus addresses are 0 control, 1 count, 2 period and 3 flag (bit 0). Each qualified tick whose increment leaves the prescaler raises the count by one. An increment taken while the count equals the period loads 0x0000 instead.
- R3: Control bits [5:4] select the prescale ratio: 00 gives 1:1, 01 gives 1:8, 10 gives 1:64 and 11 gives 1:256. Control bit 0 enables counting.
- R4: The prescaler restarts from zero on any write to the count register and on a control write that clears the enable bit.
- R5: A control write leaves the count unchanged. A count write loads the written value and wins over an increment in the same cycle.
- R6: Gated mode is control bit 3 set with internal source (bit 1 = 0). In this mode internal ticks count only while the gate level is high.
- R7: In gated mode, a falling gate edge sets the flag, and a period match does not set it.
- R8: With stop-in-idle (bit 6) set, idleIn high freezes the count. With bit 6 clear, counting continues through idle.
- R9: While sleepIn is high, counting continues only with the external source selected (bit 1 = 1) and synchronization off (bit 2 = 0). Otherwise the count holds.
- R10: With bit 2 set, an external rising edge reaches the count three clock edges after the pin changes. With bit 2 clear, it reaches the count on the first edge. Each pin edge gives exactly one increment.
- R11: Outside gated mode, a period-match reload sets the flag. Writing 1 to bit 0 at address 3 clears the flag, but a set in the same cycle wins. irqOut equals the flag AND control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr (combinational) |
| tickIn | input | 1 | Internal count-enable tick |
| extIn | input | 1 | External clock or gate pin |
| idleIn | input | 1 | Core idle status |
| sleepIn | input | 1 | Core sleep status |
| irqOut | output | 1 | Interrupt request |

## Verification
The period-match reload can set the event flag in the same cycle that software writes one to clear it. The bench provokes this by loading the count with the period value and then issuing the flag-clear write while the final tick is active. It judges the result by reading the flag on the next cycle, expecting it to remain set. In a second collision, a count write and a live tick share one edge, and the written value must appear without the extra increment.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;
  localparam logic [1:0] ADDR_FLAG   = 2'd3;

  typedef struct packed {
    logic       irqEn;     // bit 7
    logic       idleStop;  // bit 6
    logic [1:0] presSel;   // bits 5:4
    logic       gateEn;    // bit 3
    logic       syncExt;   // bit 2
    logic       extSel;    // bit 1
    logic       enable;    // bit 0
  } ctrl_t;

  typedef struct packed {
    logic countInc;
    logic gateFall;
  } strobe_t;
endpackage

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
  import gpt_pkg::*;
#(
  parameter int PRES_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  ctrl_t   ctrl,
  input  logic    presClr,
  input  logic    tickIn,
  input  logic    extIn,
  input  logic    idleIn,
  input  logic    sleepIn,
  output strobe_t strobe
);
  function automatic logic [PRES_W-1:0] presLimit(input logic [1:0] sel);
    int ratioLog;
    ratioLog = (sel == 2'd3) ? 8 : 3 * int'(sel);
    return PRES_W'((1 << ratioLog) - 1);
  endfunction

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   extLevel, extPrev, extRise, extFall;
  logic                   gatedMode, sleepOk, runOk, srcTick, preWrap;
  logic [PRES_W-1:0]      preCnt, preLimit;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], extIn};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= extIn;
      end
    end
  endgenerate

  assign extLevel = ctrl.syncExt ? syncChain[SYNC_STAGES-1] : extIn;

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extLevel;
  end

  assign extRise   = extLevel & ~extPrev;
  assign extFall   = ~extLevel & extPrev;
  assign gatedMode = ctrl.gateEn & ~ctrl.extSel;
  assign sleepOk   = ctrl.extSel & ~ctrl.syncExt;
  assign runOk     = ctrl.enable & ~(idleIn & ctrl.idleStop) & ~(sleepIn & ~sleepOk);
  assign srcTick   = ctrl.extSel ? extRise : (tickIn & (~gatedMode | extLevel));
  assign preLimit  = presLimit(ctrl.presSel);
  assign preWrap   = (preCnt >= preLimit);

  always_ff @(posedge clk) begin
    if (!rstN)                preCnt <= '0;
    else if (presClr)         preCnt <= '0;
    else if (runOk && srcTick) preCnt <= preWrap ? '0 : preCnt + 1'b1;
  end

  assign strobe.countInc = runOk & srcTick & preWrap & ~presClr;
  assign strobe.gateFall = runOk & gatedMode & extFall;

  // R4: a clear request leaves the prescaler at zero
  a_r4_pres_cleared: assert property (@(posedge clk) disable iff (!rstN)
    presClr |=> preCnt == '0);
  // R8: idle with stop-in-idle freezes the prescaler
  a_r8_idle_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (idleIn && ctrl.idleStop && !presClr) |=> $stable(preCnt));
  // R9: sleep without an asynchronous external source freezes the prescaler
  a_r9_sleep_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (sleepIn && !(ctrl.extSel && !ctrl.syncExt) && !presClr) |=> $stable(preCnt));
  // R6: a gated increment needs the gate level high
  a_r6_gate_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countInc && gatedMode) |-> extLevel);
endmodule

// File: rtl/gpt_datapath.sv
module gpt_datapath
  import gpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  input  strobe_t          strobe,
  output ctrl_t            ctrl,
  output logic             presClr,
  output logic             irqOut
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrlReg, ctrlNext;
  logic [CNT_W-1:0] count, period;
  logic             flag, flagSet, flagClr, match, gatedMode;
  logic             wrCtrl, wrCount, wrPeriod, wrFlag;

  assign wrCtrl    = busWrEn && busAddr == ADDR_CTRL;
  assign wrCount   = busWrEn && busAddr == ADDR_COUNT;
  assign wrPeriod  = busWrEn && busAddr == ADDR_PERIOD;
  assign wrFlag    = busWrEn && busAddr == ADDR_FLAG;
  assign ctrlNext  = ctrl_t'(busWrData[CTRL_W-1:0]);
  assign match     = (count == period);
  assign gatedMode = ctrlReg.gateEn & ~ctrlReg.extSel;
  assign presClr   = wrCount | (wrCtrl & ctrlReg.enable & ~ctrlNext.enable);
  assign flagSet   = (strobe.countInc & ~wrCount & match & ~gatedMode) | strobe.gateFall;
  assign flagClr   = wrFlag & busWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      period  <= '1;
      count   <= '0;
      flag    <= 1'b0;
    end else begin
      if (wrCtrl)   ctrlReg <= ctrlNext;
      if (wrPeriod) period  <= busWrData;
      if (wrCount)              count <= busWrData;
      else if (strobe.countInc) count <= match ? '0 : count + 1'b1;
      flag <= flagSet | (flag & ~flagClr);
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_CTRL:   busRdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlReg};
      ADDR_COUNT:  busRdData = count;
      ADDR_PERIOD: busRdData = period;
      default:     busRdData = {{(CNT_W-1){1'b0}}, flag};
    endcase
  end

  assign ctrl   = ctrlReg;
  assign irqOut = flag & ctrlReg.irqEn;

  // R2: an increment at the period value reloads zero
  a_r2_match_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countInc && !wrCount && match) |=> count == '0);
  // R5: a control write alone keeps the count
  a_r5_ctrl_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !strobe.countInc) |=> $stable(count));
  // R5: a count write loads exactly the written data
  a_r5_count_load: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> count == $past(busWrData));
  // R7: a gate falling edge leaves the flag set
  a_r7_gate_fall_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gateFall |=> flag);
  // R11: a clear write without a set drops the flag
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !strobe.countInc && !strobe.gateFall) |=> !flag);
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRES_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  input  logic             tickIn,
  input  logic             extIn,
  input  logic             idleIn,
  input  logic             sleepIn,
  output logic             irqOut
);
  ctrl_t   ctrl;
  strobe_t strobe;
  logic    presClr;

  gpt_ctrl #(.PRES_W(PRES_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .presClr(presClr),
    .tickIn(tickIn), .extIn(extIn), .idleIn(idleIn), .sleepIn(sleepIn),
    .strobe(strobe)
  );

  gpt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .strobe(strobe),
    .ctrl(ctrl), .presClr(presClr), .irqOut(irqOut)
  );
endmodule

// File: tb/gated_period_timer_tb.sv
`timescale 1ns/1ps
module gated_period_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWrData = 16'd0;
  logic [15:0] busRdData;
  logic        tickIn = 1'b0, extIn = 1'b0, idleIn = 1'b0, sleepIn = 1'b0;
  logic        irqOut;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  gated_period_timer u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .tickIn(tickIn),
    .extIn(extIn), .idleIn(idleIn), .sleepIn(sleepIn), .irqOut(irqOut)
  );

  function automatic int ratioOf(input int sel);
    return (sel == 3) ? 256 : (1 << (3 * sel));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  task automatic pulses(input int n);
    tickIn = 1'b1;
    repeat (n) @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic extToggle();
    extIn = 1'b1; repeat (3) @(negedge clk);
    extIn = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic expectCount(input string req, input logic [15:0] exp);
    logic [15:0] v;
    readReg(2'd1, v); check(req, v, exp);
  endtask

  task automatic expectFlag(input string req, input logic exp);
    logic [15:0] v;
    readReg(2'd3, v); check(req, v, {15'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(2'd0, v); check("R1 ctrl", v, 16'h0000);
    expectCount("R1 count", 16'h0000);
    readReg(2'd2, v); check("R1 period", v, 16'hFFFF);
    expectFlag("R1 flag", 1'b0);
    check("R1 irq", {15'd0, irqOut}, 16'd0);

    // R3 all prescale ratios, R2 counting
    for (int sel = 0; sel < 4; sel++) begin
      busWrite(2'd0, 16'h0000);
      busWrite(2'd1, 16'h0000);
      busWrite(2'd0, 16'(1 | (sel << 4)));
      pulses(3 * ratioOf(sel) - 1);
      expectCount("R3 before boundary", 16'd2);
      pulses(1);
      expectCount("R3 at boundary", 16'd3);
    end

    // R2 / R11 match reload and flag
    busWrite(2'd0, 16'h0000);
    busWrite(2'd2, 16'd4);
    busWrite(2'd1, 16'd0);
    busWrite(2'd0, 16'h0081);
    pulses(4);
    expectCount("R2 at period", 16'd4);
    expectFlag("R11 no flag yet", 1'b0);
    pulses(1);
    expectCount("R2 reload", 16'd0);
    expectFlag("R11 flag on match", 1'b1);
    check("R11 irq raised", {15'd0, irqOut}, 16'd1);
    busWrite(2'd3, 16'd1);
    expectFlag("R11 w1c", 1'b0);
    check("R11 irq dropped", {15'd0, irqOut}, 16'd0);

    // R11 set wins over clear in the same cycle
    busWrite(2'd1, 16'd4);
    tickIn = 1'b1; busWrEn = 1'b1; busAddr = 2'd3; busWrData = 16'd1;
    @(negedge clk);
    tickIn = 1'b0; busWrEn = 1'b0;
    expectFlag("R11 set wins", 1'b1);
    expectCount("R2 reload collide", 16'd0);

    // R5 count write beats a simultaneous tick
    tickIn = 1'b1; busWrEn = 1'b1; busAddr = 2'd1; busWrData = 16'd100;
    @(negedge clk);
    tickIn = 1'b0; busWrEn = 1'b0;
    busWrite(2'd2, 16'hFFFF);
    expectCount("R5 write wins", 16'd100);
    busWrite(2'd0, 16'h0001);
    expectCount("R5 ctrl keeps count", 16'd100);
    check("R11 irq masked", {15'd0, irqOut}, 16'd0);
    busWrite(2'd3, 16'd1);

    // R4 prescaler clear rules
    busWrite(2'd0, 16'h0011);
    busWrite(2'd1, 16'd0);
    pulses(5);
    busWrite(2'd1, 16'd0);
    pulses(7);
    expectCount("R4 count write clears", 16'd0);
    pulses(1);
    expectCount("R4 after 8", 16'd1);
    pulses(5);
    busWrite(2'd0, 16'h0010);
    busWrite(2'd0, 16'h0011);
    pulses(7);
    expectCount("R4 disable clears", 16'd1);
    pulses(1);
    expectCount("R4 disable clears 8", 16'd2);

    // R6 / R7 gated accumulation, no sync
    busWrite(2'd0, 16'h0000);
    busWrite(2'd1, 16'd0);
    busWrite(2'd0, 16'h0009);
    pulses(3);
    expectCount("R6 gate low", 16'd0);
    extIn = 1'b1;
    pulses(4);
    expectCount("R6 gate high", 16'd4);
    expectFlag("R7 no flag while high", 1'b0);
    extIn = 1'b0;
    pulses(1);
    expectCount("R6 gate closed", 16'd4);
    expectFlag("R7 flag on fall", 1'b1);
    busWrite(2'd3, 16'd1);
    busWrite(2'd2, 16'd5);
    extIn = 1'b1;
    pulses(2);
    expectCount("R6 gated reload", 16'd0);
    expectFlag("R7 no flag on match", 1'b0);
    extIn = 1'b0;
    @(negedge clk);
    expectFlag("R7 fall sets flag", 1'b1);
    busWrite(2'd3, 16'd1);
    busWrite(2'd2, 16'hFFFF);

    // R10 sync latency
    busWrite(2'd0, 16'h0000);
    busWrite(2'd1, 16'd0);
    busWrite(2'd0, 16'h0007);
    repeat (3) @(negedge clk);
    extIn = 1'b1;
    @(negedge clk); expectCount("R10 sync edge1", 16'd0);
    @(negedge clk); expectCount("R10 sync edge2", 16'd0);
    @(negedge clk); expectCount("R10 sync edge3", 16'd1);
    @(negedge clk); expectCount("R10 single tick", 16'd1);
    extIn = 1'b0;
    repeat (3) @(negedge clk);
    busWrite(2'd0, 16'h0003);
    extIn = 1'b1;
    @(negedge clk); expectCount("R10 async edge1", 16'd2);
    @(negedge clk); expectCount("R10 async single", 16'd2);
    extIn = 1'b0;
    @(negedge clk);

    // R8 idle
    busWrite(2'd0, 16'h0041);
    busWrite(2'd1, 16'd0);
    idleIn = 1'b1;
    pulses(5);
    expectCount("R8 idle stop", 16'd0);
    idleIn = 1'b0;
    pulses(3);
    expectCount("R8 resume", 16'd3);
    busWrite(2'd0, 16'h0001);
    idleIn = 1'b1;
    pulses(2);
    idleIn = 1'b0;
    expectCount("R8 idle run", 16'd5);

    // R9 sleep
    sleepIn = 1'b1;
    pulses(3);
    expectCount("R9 internal holds", 16'd5);
    busWrite(2'd0, 16'h0007);
    extToggle(); extToggle();
    expectCount("R9 sync holds", 16'd5);
    busWrite(2'd0, 16'h0003);
    extToggle(); extToggle();
    expectCount("R9 async counts", 16'd7);
    sleepIn = 1'b0;

    // R2 / R3 / R8 / R9 / R11 random against a bench model
    for (int round = 0; round < 4; round++) begin
      int per, sel, stp, lim, mPre, mCnt;
      logic mFlag;
      per = 3 + int'($urandom % 18);
      sel = int'($urandom % 2);
      stp = int'($urandom % 2);
      lim = ratioOf(sel) - 1;
      busWrite(2'd0, 16'h0000);
      busWrite(2'd2, 16'(per));
      busWrite(2'd1, 16'd0);
      busWrite(2'd3, 16'd1);
      busWrite(2'd0, 16'(1 | (sel << 4) | (stp << 6)));
      mPre = 0; mCnt = 0; mFlag = 1'b0;
      for (int cyc = 0; cyc < 150; cyc++) begin
        tickIn  = ($urandom % 2) != 0;
        idleIn  = ($urandom % 4) == 0;
        sleepIn = ($urandom % 8) == 0;
        if (tickIn && !(idleIn && stp != 0) && !sleepIn) begin
          if (mPre >= lim) begin
            mPre = 0;
            if (mCnt == per) begin mCnt = 0; mFlag = 1'b1; end
            else mCnt++;
          end else mPre++;
        end
        @(negedge clk);
        expectCount("R2 random count", 16'(mCnt));
        expectFlag("R11 random flag", mFlag);
      end
      tickIn = 1'b0; idleIn = 1'b0; sleepIn = 1'b0;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule